// File: doc/BRIEF.md
# Modular Add/Subtract Unit

This block adds or subtracts two wide operands modulo a value held in its own modulus register. Software loads the modulus once through a write-enable port. After that, each operation is started by a one-cycle strobe that carries the two operands and an operation select.

The unit makes exactly one correction step. For addition it forms the full sum with one extra bit and takes the modulus away once when the sum reaches or passes it. For subtraction it forms the difference and adds the modulus back once when the difference went below zero. The result is truncated to the operand width and is registered. A one-cycle valid pulse comes with it.

Operands are expected to already lie below the modulus. In that case the result also lies below it. With other operands the single correction still happens, but the result is not a full reduction. No condition flags are produced.

Top module: `modular_addsub`

## Requirements
- R1: Addition (`isSub` = 0) whose full-width sum `opA + opB` is below the modulus returns that sum unchanged.
- R2: Addition whose sum, compared with one extra carry bit, is equal to or greater than the modulus returns the sum minus the modulus, truncated to WIDTH bits. This includes sums that overflow WIDTH bits.
- R3: Subtraction (`isSub` = 1) with `opA >= opB` returns `opA - opB`.
- R4: Subtraction with `opA < opB` returns `opA - opB + modulus`, truncated to WIDTH bits.
- R5: `result` and `outValid` update at the first rising edge after `inValid` is sampled high. `outValid` is high for exactly one cycle per accepted strobe, and back-to-back strobes give back-to-back results.
- R6: While `inValid` is low, `result` holds its last value and `outValid` stays low. This is also true when the modulus register is written.
- R7: A high `modWe` loads `modIn` into the modulus register. An operation strobed in the same cycle as a modulus write uses the previous modulus.
- R8: Reset clears `result`, `outValid` and the modulus register. With a zero modulus, addition returns the sum wrapped to WIDTH bits, and subtraction returns the wrapped difference.
- R9: When both operands are below the modulus, the result is below the modulus.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Starts an operation on the current operands |
| isSub | input | 1 | 0 selects addition, 1 selects subtraction |
| opA | input | WIDTH | First operand (minuend for subtraction) |
| opB | input | WIDTH | Second operand (subtrahend for subtraction) |
| modWe | input | 1 | Write enable of the modulus register |
| modIn | input | WIDTH | New modulus value |
| outValid | output | 1 | One-cycle pulse marking a new result |
| result | output | WIDTH | Registered modular result |

## Verification
The hardest case to reach is an addition whose sum carries out of WIDTH bits. A WIDTH-bit compare would miss it, and the wrong correction would follow. Uniform random operands reduced by a small modulus almost never produce it.

The stimulus loads moduli with the top bit set, including all ones, and adds operands one below the modulus. It also hits the exact-equality sum and a subtraction against the largest operand. Random traffic then mixes operations with modulus rewrites, which are sometimes timed to land in the same cycle as an operation.

// File: rtl/modas_pkg.sv
package modas_pkg;

  // Strobes sent from the control module to the datapath.
  typedef struct packed {
    logic capture;   // register a new result this cycle
    logic doSub;     // operation is subtraction
    logic loadMod;   // write the modulus register this cycle
  } modasStrobe_t;

endpackage

// File: rtl/modas_ctrl.sv
module modas_ctrl
  import modas_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inValid,
  input  logic         isSub,
  input  logic         modWe,
  output modasStrobe_t strobe,
  output logic         outValid
);

  always_comb begin
    strobe.capture = inValid;
    strobe.doSub   = isSub;
    strobe.loadMod = modWe;
  end

  // The valid pulse follows the capture strobe by one edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) outValid <= 1'b0;
    else        outValid <= inValid;
  end

endmodule

// File: rtl/modas_datapath.sv
module modas_datapath
  import modas_pkg::*;
#(
  parameter int WIDTH            = 256,
  parameter bit SHARE_CORRECTION = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  modasStrobe_t     strobe,
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic [WIDTH-1:0] modIn,
  output logic [WIDTH-1:0] result,
  output logic [WIDTH-1:0] modulusQ
);

  localparam int XW = WIDTH + 1;  // one carry/borrow bit

  logic [XW-1:0]    sumWide;
  logic [XW-1:0]    diffWide;
  logic [XW-1:0]    modWide;
  logic             borrow;
  logic             sumGeMod;
  logic             needFix;
  logic [WIDTH-1:0] plainVal;
  logic [WIDTH-1:0] fixedVal;
  logic [WIDTH-1:0] nextVal;

  assign modWide  = {1'b0, modulusQ};
  assign sumWide  = {1'b0, opA} + {1'b0, opB};
  assign diffWide = {1'b0, opA} - {1'b0, opB};
  assign borrow   = diffWide[WIDTH];
  assign sumGeMod = (sumWide >= modWide);
  assign needFix  = strobe.doSub ? borrow : sumGeMod;
  assign plainVal = strobe.doSub ? diffWide[WIDTH-1:0] : sumWide[WIDTH-1:0];

  generate
    if (SHARE_CORRECTION) begin : g_shared
      // One adder: add the modulus, or add its complement plus one.
      logic [XW-1:0] baseVal;
      logic [XW-1:0] corrOp;
      logic [XW-1:0] corrSum;
      assign baseVal  = strobe.doSub ? diffWide : sumWide;
      assign corrOp   = strobe.doSub ? modWide : ~modWide;
      assign corrSum  = baseVal + corrOp + {{WIDTH{1'b0}}, ~strobe.doSub};
      assign fixedVal = corrSum[WIDTH-1:0];
    end else begin : g_split
      // Two adders in parallel; only a mux sits behind them.
      logic [XW-1:0] addFix;
      logic [XW-1:0] subFix;
      assign addFix   = sumWide - modWide;
      assign subFix   = diffWide + modWide;
      assign fixedVal = strobe.doSub ? subFix[WIDTH-1:0] : addFix[WIDTH-1:0];
    end
  endgenerate

  assign nextVal = needFix ? fixedVal : plainVal;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              result <= '0;
    else if (strobe.capture) result <= nextVal;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              modulusQ <= '0;
    else if (strobe.loadMod) modulusQ <= modIn;
  end

endmodule

// File: rtl/modular_addsub.sv
module modular_addsub
  import modas_pkg::*;
#(
  parameter int WIDTH            = 256,
  parameter bit SHARE_CORRECTION = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inValid,
  input  logic             isSub,
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic             modWe,
  input  logic [WIDTH-1:0] modIn,
  output logic             outValid,
  output logic [WIDTH-1:0] result
);

  modasStrobe_t     strobe;
  logic [WIDTH-1:0] modulusQ;

  modas_ctrl ctrl_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .inValid  (inValid),
    .isSub    (isSub),
    .modWe    (modWe),
    .strobe   (strobe),
    .outValid (outValid)
  );

  modas_datapath #(
    .WIDTH            (WIDTH),
    .SHARE_CORRECTION (SHARE_CORRECTION)
  ) dp_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobe   (strobe),
    .opA      (opA),
    .opB      (opB),
    .modIn    (modIn),
    .result   (result),
    .modulusQ (modulusQ)
  );

endmodule

// File: rtl/modas_checker.sv
module modas_checker #(
  parameter int W = 256
) (
  input logic         clk,
  input logic         rst_n,
  input logic         inValid,
  input logic         isSub,
  input logic [W-1:0] opA,
  input logic [W-1:0] opB,
  input logic         outValid,
  input logic [W-1:0] result,
  input logic [W-1:0] modulusQ
);

  // R5
  a_r5_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    inValid |=> outValid);

  // R5
  a_r5_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !inValid |=> !outValid);

  // R6
  a_r6_hold_result: assert property (@(posedge clk) disable iff (!rst_n)
    !inValid |=> $stable(result));

  // R3
  a_r3_plain_diff: assert property (@(posedge clk) disable iff (!rst_n)
    (inValid && isSub && (opA >= opB)) |=> (result == $past(opA - opB)));

  // R9
  a_r9_below_mod: assert property (@(posedge clk) disable iff (!rst_n)
    (inValid && (opA < modulusQ) && (opB < modulusQ)) |=> (result < $past(modulusQ)));

endmodule

bind modular_addsub modas_checker #(.W(WIDTH)) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .inValid  (inValid),
  .isSub    (isSub),
  .opA      (opA),
  .opB      (opB),
  .outValid (outValid),
  .result   (result),
  .modulusQ (modulusQ)
);

// File: tb/modular_addsub_tb_top.sv
module modular_addsub_tb_top;

  localparam int W = 256;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         inValid = 1'b0;
  logic         isSub = 1'b0;
  logic [W-1:0] opA = '0;
  logic [W-1:0] opB = '0;
  logic         modWe = 1'b0;
  logic [W-1:0] modIn = '0;
  logic         outValid;
  logic [W-1:0] result;

  int testCount = 0;
  int failCount = 0;
  bit finished  = 1'b0;

  // bench-side model state
  logic [W-1:0] curMod  = '0;
  logic         pendValid = 1'b0;
  logic [W-1:0] pendExp = '0;
  string        pendTag = "";
  logic         pendBelow = 1'b0;
  logic [W-1:0] pendMod = '0;
  logic [W-1:0] lastRes = '0;

  always #5 clk = ~clk;

  modular_addsub #(.WIDTH(W)) dut_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .inValid  (inValid),
    .isSub    (isSub),
    .opA      (opA),
    .opB      (opB),
    .modWe    (modWe),
    .modIn    (modIn),
    .outValid (outValid),
    .result   (result)
  );

  function automatic logic [W-1:0] refModOp(input logic s, input logic [W-1:0] a,
                                            input logic [W-1:0] b, input logic [W-1:0] m);
    logic [W:0] t;
    if (!s) begin
      t = {1'b0, a} + {1'b0, b};
      if (t >= {1'b0, m}) t = t - {1'b0, m};
    end else begin
      t = {1'b0, a} - {1'b0, b};
      if (a < b) t = t + {1'b0, m};
    end
    return t[W-1:0];
  endfunction

  function automatic string reqTag(input logic s, input logic [W-1:0] a,
                                   input logic [W-1:0] b, input logic [W-1:0] m);
    logic [W:0] t;
    t = {1'b0, a} + {1'b0, b};
    if (s) return (a >= b) ? "R3" : "R4";
    return (t >= {1'b0, m}) ? "R2" : "R1";
  endfunction

  function automatic logic [W-1:0] rand256();
    logic [W-1:0] r = '0;
    for (int i = 0; i < W / 32; i++) r = {r[W-33:0], $urandom()};
    return r;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [W-1:0] act,
                       input logic [W-1:0] exp);
    testCount++;
    if (!ok) begin
      failCount++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", testCount, failCount);
      $finish;
    end
  endtask

  // One cycle: check what the previous cycle produced, then drive the next one.
  task automatic step(input logic v, input logic s, input logic [W-1:0] a,
                      input logic [W-1:0] b, input logic we, input logic [W-1:0] m,
                      input string tagOverride);
    @(negedge clk);
    check(outValid === pendValid, "R5 outValid", {{(W-1){1'b0}}, outValid},
          {{(W-1){1'b0}}, pendValid});
    if (pendValid) begin
      check(result === pendExp, pendTag, result, pendExp);
      if (pendBelow) check(result < pendMod, "R9 below modulus", result, pendMod);
      lastRes = pendExp;
    end else begin
      check(result === lastRes, "R6 hold", result, lastRes);
    end
    inValid = v; isSub = s; opA = a; opB = b; modWe = we; modIn = m;
    pendValid = v;
    if (v) begin
      pendExp   = refModOp(s, a, b, curMod);
      pendTag   = (tagOverride != "") ? tagOverride : reqTag(s, a, b, curMod);
      pendBelow = (a < curMod) && (b < curMod);
      pendMod   = curMod;
    end
    if (we) curMod = m;  // same-cycle operation used the old value (R7)
  endtask

  initial begin
    logic [W-1:0] m1;
    logic [W-1:0] ones;
    void'($urandom(32'h5eed_2024));
    ones = '1;
    m1 = rand256() | {1'b1, {(W-1){1'b0}}};
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R8 reset state
    check(outValid === 1'b0, "R8 reset outValid", {{(W-1){1'b0}}, outValid}, '0);
    check(result === '0, "R8 reset result", result, '0);

    // R8 zero modulus after reset
    step(1'b1, 1'b0, ones, W'(2), 1'b0, '0, "R8 add zero modulus");
    step(1'b1, 1'b1, W'(5), W'(9), 1'b0, '0, "R8 sub zero modulus");
    // R7 collision: op sees old (zero) modulus
    step(1'b1, 1'b0, W'(3), W'(4), 1'b1, m1, "R7 same-cycle write");
    // R2 carry past WIDTH, R2 equality, R1, R4, R3
    step(1'b1, 1'b0, m1 - 1, m1 - 1, 1'b0, '0, "R2 carry out");
    step(1'b1, 1'b0, m1 - 1, W'(1), 1'b0, '0, "R2 sum equals modulus");
    step(1'b1, 1'b0, W'(1), W'(2), 1'b0, '0, "R1 small sum");
    step(1'b1, 1'b1, '0, m1 - 1, 1'b0, '0, "R4 borrow");
    step(1'b1, 1'b1, m1 - 1, m1 - 1, 1'b0, '0, "R3 equal operands");
    // R6 modulus write with no operation must not touch result
    step(1'b0, 1'b0, W'(7), W'(7), 1'b1, ones, "");
    step(1'b0, 1'b0, '0, '0, 1'b0, '0, "");
    step(1'b1, 1'b0, ones - 1, ones - 1, 1'b0, '0, "R2 all-ones modulus");
    step(1'b1, 1'b1, W'(1), ones - 1, 1'b0, '0, "R4 all-ones modulus");

    // random traffic
    for (int n = 0; n < 600; n++) begin
      logic         v;
      logic         s;
      logic         we;
      logic [W-1:0] a;
      logic [W-1:0] b;
      logic [W-1:0] m;
      v  = ($urandom() % 4) != 0;
      s  = $urandom() % 2;
      we = ($urandom() % 24) == 0;
      m  = rand256();
      if ($urandom() % 2) m = m >> ($urandom() % W);
      if ($urandom() % 3 == 0) m = m | {1'b1, {(W-1){1'b0}}};
      a = rand256();
      b = rand256();
      if (curMod != '0 && ($urandom() % 8) != 0) begin
        a = a % curMod;
        b = b % curMod;
        if ($urandom() % 10 == 0) a = curMod - 1;
        if ($urandom() % 10 == 0) b = curMod - 1;
      end
      step(v, s, a, b, we, m, "");
    end
    step(1'b0, 1'b0, '0, '0, 1'b0, '0, "");
    step(1'b0, 1'b0, '0, '0, 1'b0, '0, "");
    finishRun();
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failCount++;
      $display("FAIL R5 watchdog actual=running expected=finished");
      finishRun();
    end
  end

endmodule